// File: doc/BRIEF.md
# In-Memory Descending Sort and Median Engine

The engine finds the median of a list of unsigned bytes held in a byte-wide, single-ported RAM. It sorts the list in place with a bubble sort that exits early, then copies the middle element to a fixed result location. A one-cycle `start` pulse launches a run. `busy` stays high for the whole run, and `done` pulses once in its final cycle. The run takes its header from fixed locations: address 0 holds the element count, address 1 holds the address of the first element, and the median is written to address 2.

Each pass compares neighbouring bytes and swaps them when the lower address holds the smaller value, so the list ends up in descending order. Each pass covers one pair fewer than the pass before it. Sorting stops after the first pass that makes no swap. The byte now at the lower neighbour of a pair is held in a register, so a pair costs one RAM read, plus two writes when the pair is swapped.

A host side port reaches the same RAM whenever the engine is idle, and the testbench uses it to load and read back the RAM. Host reads return data one cycle after the request. The port has no flow control. The host must only use it while `busy` is low; host requests made during a run are dropped.

Top module: `median_sort_engine`

## Requirements
- R1: A `start` pulse while idle raises `busy` at the next clock edge, and `busy` stays high until the run ends. A `start` pulse while `busy` is high has no effect on the run, its duration or its result.
- R2: A run reads the element count from address 0 and the array base address from address 1, and never writes either of these addresses.
- R3: After a run, the array occupies addresses base to base+count-1 in descending order (the value at a lower address is greater than or equal to the value at the next address). Two equal neighbours are never swapped.
- R4: A swap is two consecutive write cycles. The first writes the larger value to the lower address of the pair, and the second writes the smaller value to the next address.
- R5: The first pass compares count-1 pairs, and each later pass compares one pair fewer. No byte outside the array, other than address 2, is written.
- R6: Sorting ends after a pass with no swap. For an array already in descending order, a run keeps `busy` high for exactly 8+2*(count-1) cycles. For count 1, it keeps `busy` high for exactly 6 cycles.
- R7: At the end of a run, address 2 holds the element at sorted position (count-1)/2. For count 1, this is the single element.
- R8: `done` is high for exactly one cycle, the last cycle in which `busy` is high. `busy` is low in the following cycle, and both are low after reset.
- R9: While idle, a host write (`host_en`=1, `host_we`=1) stores `host_wdata` at `host_addr`. A host read (`host_en`=1, `host_we`=0) presents the byte on `host_rdata` from the next clock edge onwards. Host writes while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch pulse |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse in the last busy cycle |
| host_en | input | 1 | Host RAM access request |
| host_we | input | 1 | Host write when 1, read when 0 |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |

## Verification
The assertions assume three things about the inputs: the count is odd and at least one; the array lies clear of addresses 0 to 2 and does not wrap past the top of the RAM; and `start` arrives as a short pulse. Every directed scenario preloads a header and an array that meet these conditions. The only host activity during a run is the single deliberate write to a location outside the array, and the bench reads that location back afterwards to check that the write was ignored. Swap ordering and the per-pass limit are checked against the RAM write traffic as it happens. Results and run lengths are checked at the ports against a reference sort computed in the bench.

// File: rtl/median_pkg.sv
package median_pkg;

  localparam int unsigned HDR_COUNT  = 0;
  localparam int unsigned HDR_BASE   = 1;
  localparam int unsigned HDR_RESULT = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_CNT,
    ST_RD_BASE,
    ST_SETUP,
    ST_RD_FIRST,
    ST_RD_NEXT,
    ST_CMP,
    ST_WR_HI,
    ST_PASS_END,
    ST_RD_MED,
    ST_WR_MED,
    ST_DONE
  } eng_state_t;

endpackage

// File: rtl/msort_ram.sv
module msort_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // one access per cycle: either a read or a write
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem_q[addr] <= wdata;
      else    rdata       <= mem_q[addr];
    end
  end
endmodule

// File: rtl/msort_arb.sv
module msort_arb #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          eng_own,
  input  logic          eng_en,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  // the engine owns the RAM for the whole run; host requests are dropped
  always_comb begin
    if (eng_own) begin
      ram_en    = eng_en;
      ram_we    = eng_we;
      ram_addr  = eng_addr;
      ram_wdata = eng_wdata;
    end else begin
      ram_en    = host_en;
      ram_we    = host_we;
      ram_addr  = host_addr;
      ram_wdata = host_wdata;
    end
  end
endmodule

// File: rtl/msort_fsm.sv
module msort_fsm
  import median_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] rdata,
  output logic          eng_en,
  output logic          eng_we,
  output logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_wdata,
  output logic          busy,
  output logic          done,
  output logic          swap_first,
  output logic          pass_restart,
  output logic [AW-1:0] limit
);
  eng_state_t    state_q, state_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] limit_q, limit_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          swapped_q, swapped_d;
  logic          pend_q, pend_d;

  logic [AW-1:0] lo_addr, hi_addr, med_addr, idx_inc;
  logic          last_pair;

  assign lo_addr   = AW'(base_q + idx_q);
  assign hi_addr   = AW'(base_q + idx_q + 1'b1);
  assign med_addr  = AW'(base_q + (AW'(cnt_q - 1'b1) >> 1));
  assign idx_inc   = AW'(idx_q + 1'b1);
  assign last_pair = (idx_inc == limit_q);

  assign busy  = (state_q != ST_IDLE);
  assign done  = (state_q == ST_DONE);
  assign limit = limit_q;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    base_d       = base_q;
    limit_d      = limit_q;
    idx_d        = idx_q;
    hold_d       = hold_q;
    swapped_d    = swapped_q;
    pend_d       = pend_q;
    eng_en       = 1'b0;
    eng_we       = 1'b0;
    eng_addr     = '0;
    eng_wdata    = '0;
    swap_first   = 1'b0;
    pass_restart = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RD_CNT;
      ST_RD_CNT: begin
        eng_en   = 1'b1;
        eng_addr = AW'(HDR_COUNT);
        state_d  = ST_RD_BASE;
      end
      ST_RD_BASE: begin
        eng_en   = 1'b1;
        eng_addr = AW'(HDR_BASE);
        cnt_d    = AW'(rdata);
        state_d  = ST_SETUP;
      end
      ST_SETUP: begin
        base_d    = AW'(rdata);
        limit_d   = AW'(cnt_q - 1'b1);
        idx_d     = '0;
        swapped_d = 1'b0;
        state_d   = (cnt_q <= AW'(1)) ? ST_RD_MED : ST_RD_FIRST;
      end
      ST_RD_FIRST: begin
        eng_en   = 1'b1;
        eng_addr = lo_addr;
        pend_d   = 1'b1;
        state_d  = ST_RD_NEXT;
      end
      ST_RD_NEXT: begin
        eng_en   = 1'b1;
        eng_addr = hi_addr;
        if (pend_q) begin
          hold_d = rdata;
          pend_d = 1'b0;
        end
        state_d = ST_CMP;
      end
      ST_CMP: begin
        if (hold_q < rdata) begin
          eng_en     = 1'b1;
          eng_we     = 1'b1;
          eng_addr   = lo_addr;
          eng_wdata  = rdata;
          swap_first = 1'b1;
          swapped_d  = 1'b1;
          state_d    = ST_WR_HI;
        end else begin
          hold_d  = rdata;
          idx_d   = idx_inc;
          state_d = last_pair ? ST_PASS_END : ST_RD_NEXT;
        end
      end
      ST_WR_HI: begin
        eng_en    = 1'b1;
        eng_we    = 1'b1;
        eng_addr  = hi_addr;
        eng_wdata = hold_q;
        idx_d     = idx_inc;
        state_d   = last_pair ? ST_PASS_END : ST_RD_NEXT;
      end
      ST_PASS_END: begin
        if (!swapped_q || limit_q <= AW'(1)) begin
          state_d = ST_RD_MED;
        end else begin
          limit_d      = AW'(limit_q - 1'b1);
          idx_d        = '0;
          swapped_d    = 1'b0;
          pass_restart = 1'b1;
          state_d      = ST_RD_FIRST;
        end
      end
      ST_RD_MED: begin
        eng_en   = 1'b1;
        eng_addr = med_addr;
        state_d  = ST_WR_MED;
      end
      ST_WR_MED: begin
        eng_en    = 1'b1;
        eng_we    = 1'b1;
        eng_addr  = AW'(HDR_RESULT);
        eng_wdata = rdata;
        state_d   = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      base_q    <= '0;
      limit_q   <= '0;
      idx_q     <= '0;
      hold_q    <= '0;
      swapped_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      base_q    <= base_d;
      limit_q   <= limit_d;
      idx_q     <= idx_d;
      hold_q    <= hold_d;
      swapped_q <= swapped_d;
      pend_q    <= pend_d;
    end
  end
endmodule

// File: rtl/median_sort_engine.sv
module median_sort_engine #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  logic          eng_en, eng_we;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_wdata;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic          swap_first, pass_restart;
  logic [AW-1:0] limit_q;

  msort_fsm #(.AW(AW), .DW(DW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rdata(ram_rdata),
    .eng_en(eng_en), .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .busy(busy), .done(done), .swap_first(swap_first),
    .pass_restart(pass_restart), .limit(limit_q)
  );

  msort_arb #(.AW(AW), .DW(DW)) arb_i (
    .eng_own(busy), .eng_en(eng_en), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  msort_ram #(.AW(AW), .DW(DW)) ram_i (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign host_rdata = ram_rdata;
endmodule

// File: rtl/median_sort_checker.sv
module median_sort_checker #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic          swap_first,
  input logic          pass_restart,
  input logic [AW-1:0] limit_q
);
  p_start_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  p_hdr_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ram_we |-> ram_addr > AW'(1));

  p_swap_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_first |=> ram_we && ram_addr == AW'($past(ram_addr) + 1'b1)
                   && ram_wdata < $past(ram_wdata));

  p_limit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_restart |=> limit_q == AW'($past(limit_q) - 1'b1));

  p_result_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ram_we) && $past(ram_addr) == AW'(2));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind median_sort_engine median_sort_checker #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
  .swap_first(swap_first), .pass_restart(pass_restart), .limit_q(limit_q)
);

// File: tb/median_sort_engine_tb_top.sv
module median_sort_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done;
  logic       host_en = 1'b0, host_we = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic [7:0] host_rdata;

  int checks = 0, fails = 0;
  int run_cycles, done_seen, done_last;
  logic [7:0] ref_arr [256];

  always #10 clk = ~clk;

  median_sort_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_en = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_en = 0;
    d = host_rdata;
  endtask

  // mid_start: extra start pulse a few cycles into the run
  // mid_wr: host write to 0xF0 during the run
  task automatic run(input bit mid_start, input bit mid_wr);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    run_cycles = 0; done_seen = 0; done_last = 0;
    while (busy && run_cycles < 5000) begin
      run_cycles++;
      if (done) begin done_seen++; done_last = 1; end
      else done_last = 0;
      if (run_cycles == 3 && mid_start) start = 1;
      else if (run_cycles == 4 && mid_wr) begin
        host_en = 1; host_we = 1; host_addr = 8'hF0; host_wdata = 8'h5A;
      end else begin
        start = 0; host_en = 0; host_we = 0;
      end
      @(negedge clk);
    end
    start = 0; host_en = 0; host_we = 0;
  endtask

  // load header and array; ref_arr gets the descending reference
  task automatic load(input int n, input logic [7:0] base, input logic [7:0] vals [16]);
    host_wr(8'd0, 8'(n));
    host_wr(8'd1, base);
    host_wr(8'd2, 8'h00);
    host_wr(8'(base - 1), 8'hC3);
    host_wr(8'(base + n), 8'h3C);
    for (int i = 0; i < n; i++) begin
      host_wr(8'(base + i), vals[i]);
      ref_arr[i] = vals[i];
    end
    for (int i = 0; i < n; i++)
      for (int j = 0; j + 1 < n - i; j++)
        if (ref_arr[j] < ref_arr[j+1]) begin
          logic [7:0] t;
          t = ref_arr[j]; ref_arr[j] = ref_arr[j+1]; ref_arr[j+1] = t;
        end
  endtask

  task automatic verify(input int n, input logic [7:0] base);
    logic [7:0] d;
    int bad;
    host_rd(8'd0, d); chk(d == 8'(n), "R2 count kept", d, n);
    host_rd(8'd1, d); chk(d == base, "R2 base kept", d, base);
    host_rd(8'd2, d); chk(d == ref_arr[(n-1)/2], "R7 median", d, ref_arr[(n-1)/2]);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      host_rd(8'(base + i), d);
      if (d != ref_arr[i]) begin
        bad++;
        chk(0, "R3 sorted element", d, ref_arr[i]);
      end
    end
    if (bad == 0) chk(1, "R3 sorted", 0, 0);
    host_rd(8'(base - 1), d); chk(d == 8'hC3, "R5 below array", d, 8'hC3);
    host_rd(8'(base + n), d); chk(d == 8'h3C, "R5 above array", d, 8'h3C);
    chk(done_seen == 1 && done_last == 1, "R8 done pulse", done_seen, 1);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R8 busy after reset", busy, 0);
    chk(done == 0, "R8 done after reset", done, 0);
  endtask

  task automatic t_host_port;
    logic [7:0] d;
    host_wr(8'h80, 8'hA7);
    host_rd(8'h80, d);
    chk(d == 8'hA7, "R9 host write/read", d, 8'hA7);
  endtask

  task automatic t_presorted;
    logic [7:0] v [16];
    for (int i = 0; i < 16; i++) v[i] = 8'(200 - 20 * i);
    load(9, 8'h10, v);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, "R1 busy after start", busy, 1);
    run_cycles = 1; done_seen = 0; done_last = 0;
    while (busy && run_cycles < 5000) begin
      if (done) begin done_seen++; done_last = 1; end else done_last = 0;
      @(negedge clk);
      if (busy) run_cycles++;
    end
    chk(run_cycles == 24, "R6 sorted early exit", run_cycles, 24);
    verify(9, 8'h10);
  endtask

  task automatic t_mixed;
    logic [7:0] v [16];
    for (int i = 0; i < 16; i++) v[i] = 8'((i * 73 + 29) ^ (i * 11));
    load(11, 8'h40, v);
    run(0, 0);
    verify(11, 8'h40);
  endtask

  task automatic t_ascending;
    logic [7:0] v [16];
    for (int i = 0; i < 16; i++) v[i] = 8'(3 + 17 * i);
    load(7, 8'h60, v);
    run(0, 0);
    verify(7, 8'h60);
  endtask

  task automatic t_equal;
    logic [7:0] v [16];
    for (int i = 0; i < 16; i++) v[i] = 8'h44;
    load(5, 8'h30, v);
    run(0, 0);
    chk(run_cycles == 16, "R3 equal pairs not swapped", run_cycles, 16);
    verify(5, 8'h30);
  endtask

  task automatic t_single;
    logic [7:0] v [16];
    for (int i = 0; i < 16; i++) v[i] = 8'hE9;
    load(1, 8'h50, v);
    run(0, 0);
    chk(run_cycles == 6, "R6 single element", run_cycles, 6);
    verify(1, 8'h50);
  endtask

  task automatic t_one_swap;
    logic [7:0] v [16];
    logic [7:0] d;
    for (int i = 0; i < 16; i++) v[i] = 8'h00;
    v[0] = 8'd1; v[1] = 8'd5; v[2] = 8'd0;
    load(3, 8'h70, v);
    run(0, 0);
    chk(run_cycles == 17, "R5 shorter second pass", run_cycles, 17);
    host_rd(8'h70, d); chk(d == 8'd5, "R4 larger to lower address", d, 5);
    host_rd(8'h71, d); chk(d == 8'd1, "R4 smaller to next address", d, 1);
    verify(3, 8'h70);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v [16];
    logic [7:0] d;
    for (int i = 0; i < 16; i++) v[i] = 8'(250 - 30 * i);
    load(5, 8'h20, v);
    host_wr(8'hF0, 8'h11);
    run(1, 1);
    chk(run_cycles == 16, "R1 start while busy ignored", run_cycles, 16);
    host_rd(8'hF0, d);
    chk(d == 8'h11, "R9 host write while busy ignored", d, 8'h11);
    verify(5, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_host_port();
    t_presorted();
    t_mixed();
    t_ascending();
    t_equal();
    t_single();
    t_one_swap();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule